// File: doc/BRIEF.md
# Predicated Segment Load-Replicate Unit

This unit carries out a vector load of sixteen 16-bit elements that together fill one 256-bit segment. A 16-bit lane mask decides, lane by lane, whether an element is fetched. The assembled segment is then copied into every 256-bit slice of a destination register whose width is a parameter: 256, 512, 1024 or 2048 bits. A 128-bit width is not supported.

A caller pulses a start strobe with a base address, a signed 4-bit immediate and the mask for the lowest segment. Only those sixteen mask bits are wired to the unit, because the mask bits of higher lanes never affect the result. The unit then walks the active lanes from lowest to highest. It sends one read per active lane over a valid/ready request channel and waits for that read's response before it sends the next one. Inactive lanes are never read and are written as zero. When the last response has arrived, the whole register is written at once and a one-cycle completion pulse follows. A fault response aborts the load, reports the lane that faulted and leaves the register untouched.

Top module: `seg_ldrep_unit`

## Requirements
- R1: After reset, `vreg_o` is all zero and `busy_o`, `req_valid_o`, `done_o` and `fault_o` are low.
- R2: The read for lane i (0..15) targets base + sext(imm) * 32 + 2*i, computed modulo 2^AW. The immediate is a 4-bit two's-complement value, so its offset ranges from -256 to +224 bytes.
- R3: A read is issued only for a lane whose mask bit is 1. Reads go out in ascending lane order, where mask bit i governs lane i.
- R4: Only one read is outstanding at a time. While `req_valid_o` is high and `req_ready_i` is low, both the request and its address hold steady.
- R5: In the loaded segment, lane i occupies bits [16*i+15 : 16*i]. An active lane holds the data returned for it, and an inactive lane holds zero.
- R6: Every 256-bit slice of `vreg_o` equals the lowest slice.
- R7: A response with `rsp_fault_i` set ends the operation. `fault_o` is then high for exactly one cycle, `fault_lane_o` gives the lane index, `vreg_o` keeps its old value, `done_o` stays low and no further read is issued.
- R8: On the clock edge that accepts the last active lane's response, `vreg_o` takes the new value. `done_o` is high for exactly the one cycle after that edge.
- R9: If all sixteen mask bits are zero, no read is issued. In the cycle after the start edge, `done_o` is high and `vreg_o` is all zero.
- R10: `start_i` and the operand inputs are ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| base_i | input | AW | Base byte address |
| imm_i | input | 4 | Signed immediate, scaled by 32 bytes |
| mask_i | input | 16 | Lane enables of the lowest segment, bit i for lane i |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | AW | Read byte address |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | 16 | Read response element |
| rsp_fault_i | input | 1 | Read response carries a fault |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle abort pulse |
| fault_lane_o | output | 4 | Lane index of the last fault |
| vreg_o | output | VLEN | Destination register |

## Verification
The assertions check the request handshake on every cycle: a stalled request must hold steady, at most one read may be in flight, and every read must go to a lane that is still pending. They also check continuously that every slice of the register matches the lowest one, that a fault leaves the register as it was, that completion and fault pulses last one cycle and never coincide, and that an all-zero mask completes at once. Only the bench scenarios can show that each address has the right offset and lane order, that returned data lands in the right lane, and that a new start during a busy operation has no effect.

// File: rtl/seg_ldrep_pkg.sv
package seg_ldrep_pkg;
  localparam int ELEM_W    = 16;
  localparam int SEG_W     = 256;
  localparam int SEG_LANES = SEG_W / ELEM_W;
  localparam int LANE_W    = $clog2(SEG_LANES);
  localparam int IMM_W     = 4;
  localparam int IMM_SHIFT = $clog2(SEG_W / 8);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ldrep_state_e;
endpackage

// File: rtl/seg_ldrep_pick.sv
module seg_ldrep_pick #(
  parameter int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] pend_i,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/seg_ldrep_repl.sv
module seg_ldrep_repl #(
  parameter int SW   = 256,
  parameter int NREP = 2
) (
  input  logic [SW-1:0]      seg_i,
  output logic [SW*NREP-1:0] full_o
);
  for (genvar k = 0; k < NREP; k++) begin : g_copy
    assign full_o[k*SW +: SW] = seg_i;
  end
endmodule

// File: rtl/seg_ldrep_unit.sv
module seg_ldrep_unit
  import seg_ldrep_pkg::*;
#(
  parameter int VLEN = 512,
  parameter int AW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [AW-1:0]        base_i,
  input  logic [IMM_W-1:0]     imm_i,
  input  logic [SEG_LANES-1:0] mask_i,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [AW-1:0]        req_addr_o,
  input  logic                 rsp_valid_i,
  input  logic [ELEM_W-1:0]    rsp_data_i,
  input  logic                 rsp_fault_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [LANE_W-1:0]    fault_lane_o,
  output logic [VLEN-1:0]      vreg_o
);
  localparam int NSEG = VLEN / SEG_W;

  function automatic logic [AW-1:0] seg_base(input logic [AW-1:0] b,
                                             input logic [IMM_W-1:0] im);
    return b + {{(AW-IMM_W-IMM_SHIFT){im[IMM_W-1]}}, im, {IMM_SHIFT{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] elem_addr(input logic [AW-1:0] ea,
                                              input logic [LANE_W-1:0] ln);
    return ea + {{(AW-LANE_W-1){1'b0}}, ln, 1'b0};
  endfunction

  ldrep_state_e         state_q;
  logic [AW-1:0]        ea_q;
  logic [SEG_LANES-1:0] pend_q;
  logic [SEG_W-1:0]     seg_q;
  logic [VLEN-1:0]      vreg_q;
  logic                 done_q, fault_q;
  logic [LANE_W-1:0]    flane_q;

  // named internal events
  logic [LANE_W-1:0]    cur_lane;
  logic [SEG_LANES-1:0] pend_after;
  logic [SEG_W-1:0]     seg_next;
  logic [VLEN-1:0]      vreg_fill;
  logic                 take_start, zero_mask, req_fire, rsp_fire;
  logic                 bad_beat, last_beat;

  seg_ldrep_pick #(.N(SEG_LANES)) u_pick (
    .pend_i (pend_q),
    .idx_o  (cur_lane)
  );

  always_comb begin
    seg_next = seg_q;
    seg_next[cur_lane*ELEM_W +: ELEM_W] = rsp_data_i;
    pend_after = pend_q;
    pend_after[cur_lane] = 1'b0;
  end

  seg_ldrep_repl #(.SW(SEG_W), .NREP(NSEG)) u_repl (
    .seg_i  (seg_next),
    .full_o (vreg_fill)
  );

  assign take_start = (state_q == ST_IDLE) && start_i;
  assign zero_mask  = (mask_i == '0);
  assign req_fire   = (state_q == ST_REQ) && req_ready_i;
  assign rsp_fire   = (state_q == ST_WAIT) && rsp_valid_i;
  assign bad_beat   = rsp_fire && rsp_fault_i;
  assign last_beat  = rsp_fire && !rsp_fault_i && (pend_after == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      pend_q  <= '0;
      seg_q   <= '0;
      vreg_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flane_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_start) begin
            ea_q  <= seg_base(base_i, imm_i);
            seg_q <= '0;
            if (zero_mask) begin
              vreg_q <= '0;
              done_q <= 1'b1;
            end else begin
              pend_q  <= mask_i;
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (req_fire) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (bad_beat) begin
            fault_q <= 1'b1;
            flane_q <= cur_lane;
            pend_q  <= '0;
            state_q <= ST_IDLE;
          end else if (rsp_fire) begin
            seg_q  <= seg_next;
            pend_q <= pend_after;
            if (last_beat) begin
              vreg_q  <= vreg_fill;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o  = (state_q == ST_REQ);
  assign req_addr_o   = elem_addr(ea_q, cur_lane);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_lane_o = flane_q;
  assign vreg_o       = vreg_q;
endmodule

// File: rtl/seg_ldrep_chk.sv
module seg_ldrep_chk
  import seg_ldrep_pkg::*;
#(
  parameter int VLEN = 512,
  parameter int AW   = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic [SEG_LANES-1:0] mask_i,
  input logic                 req_valid_o,
  input logic                 req_ready_i,
  input logic [AW-1:0]        req_addr_o,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 fault_o,
  input logic [VLEN-1:0]      vreg_o,
  input logic [SEG_LANES-1:0] pend_q,
  input logic [LANE_W-1:0]    cur_lane,
  input logic                 req_fire
);
  localparam int NSEG = VLEN / SEG_W;

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

  p_single_flight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid_o);

  p_active_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> pend_q[cur_lane]);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !req_valid_o);

  p_fault_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $stable(vreg_o) && !done_o);

  p_fault_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> !fault_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_zero_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i && (mask_i == '0) |=> done_o && (vreg_o == '0) && !busy_o);

  for (genvar k = 1; k < NSEG; k++) begin : g_slice
    p_slice_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vreg_o[k*SEG_W +: SEG_W] == vreg_o[SEG_W-1:0]);
  end
endmodule

bind seg_ldrep_unit seg_ldrep_chk #(.VLEN(VLEN), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mask_i      (mask_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_addr_o  (req_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .vreg_o      (vreg_o),
  .pend_q      (pend_q),
  .cur_lane    (cur_lane),
  .req_fire    (req_fire)
);

// File: tb/tb_seg_ldrep_unit.sv
module tb_seg_ldrep_unit;
  localparam int VLEN = 512;
  localparam int AW   = 32;
  localparam int NV   = 5;

  localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h0000_2000, 32'h0000_3000,
                                          32'h0000_40F0, 32'h0000_0010};
  localparam logic [3:0]  V_IMM  [NV] = '{4'h0, 4'h7, 4'h8, 4'hF, 4'h8};
  localparam logic [15:0] V_MASK [NV] = '{16'hFFFF, 16'h8001, 16'hAAAA, 16'h0100, 16'h5555};
  localparam int          V_DLY  [NV] = '{0, 1, 2, 0, 1};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, req_ready_i = 1'b0, rsp_valid_i = 1'b0, rsp_fault_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [3:0]    imm_i = '0;
  logic [15:0]   mask_i = '0;
  logic [15:0]   rsp_data_i = '0;
  logic          req_valid_o, busy_o, done_o, fault_o;
  logic [AW-1:0] req_addr_o;
  logic [3:0]    fault_lane_o;
  logic [VLEN-1:0] vreg_o;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  seg_ldrep_unit #(.VLEN(VLEN), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .imm_i(imm_i),
    .mask_i(mask_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i),
    .rsp_fault_i(rsp_fault_i), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
    .fault_lane_o(fault_lane_o), .vreg_o(vreg_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    return {a[8:1], a[16:9]} ^ 16'h5A3C;
  endfunction

  function automatic logic [VLEN-1:0] spread(input logic [255:0] s);
    logic [VLEN-1:0] r;
    for (int j = 0; j < VLEN; j++) r[j] = s[j % 256];
    return r;
  endfunction

  // flt: lane that answers with a fault (16 = none); noisy: keep start high with junk while busy
  task automatic run_op(input logic [31:0] b, input logic [3:0] im, input logic [15:0] m,
                        input int flt, input int dly, input bit noisy);
    logic [255:0] seg = '0;
    logic [VLEN-1:0] prev = vreg_o;
    int off = im[3] ? int'(im) - 16 : int'(im);
    logic [AW-1:0] ea = b + AW'(off * 32);
    @(negedge clk);
    start_i = 1'b1; base_i = b; imm_i = im; mask_i = m;
    @(negedge clk);
    if (noisy) begin
      base_i = ~b; imm_i = ~im; mask_i = ~m;
    end else begin
      start_i = 1'b0;
    end
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        logic [AW-1:0] exp_a = ea + AW'(2 * i);
        int n = 0;
        while (!req_valid_o && n < 50) begin @(negedge clk); n++; end
        chk(req_valid_o && req_addr_o == exp_a, "R2/R3 address", VLEN'(req_addr_o), VLEN'(exp_a));
        for (int d = 0; d < dly; d++) begin
          @(negedge clk);
          chk(req_valid_o && req_addr_o == exp_a, "R4 hold", VLEN'(req_addr_o), VLEN'(exp_a));
        end
        req_ready_i = 1'b1;
        @(negedge clk);
        req_ready_i = 1'b0;
        chk(!req_valid_o, "R4 one outstanding", VLEN'(req_valid_o), '0);
        rsp_valid_i = 1'b1; rsp_data_i = mem_word(exp_a); rsp_fault_i = (i == flt);
        @(negedge clk);
        rsp_valid_i = 1'b0; rsp_fault_i = 1'b0;
        if (i == flt) begin
          start_i = 1'b0;
          chk(fault_o && fault_lane_o == 4'(i), "R7 fault lane",
              VLEN'({fault_o, fault_lane_o}), VLEN'({1'b1, 4'(i)}));
          chk(vreg_o == prev && !done_o, "R7 register kept", vreg_o, prev);
          @(negedge clk);
          chk(!fault_o && !req_valid_o && !busy_o, "R7 pulse and stop",
              VLEN'({fault_o, req_valid_o, busy_o}), '0);
          return;
        end
        seg[16*i +: 16] = mem_word(exp_a);
      end
    end
    start_i = 1'b0;
    chk(!req_valid_o, "R9/R3 no extra request", VLEN'(req_valid_o), '0);
    chk(done_o == 1'b1, "R8/R9 done", VLEN'(done_o), VLEN'(1));
    chk(vreg_o == spread(seg), "R5/R6 register", vreg_o, spread(seg));
    @(negedge clk);
    chk(!done_o, "R8 single pulse", VLEN'(done_o), '0);
  endtask

  initial begin
    for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vreg_o == '0 && !busy_o && !req_valid_o && !done_o && !fault_o, "R1 reset",
        vreg_o, '0);

    for (int v = 0; v < NV; v++)
      run_op(V_BASE[v], V_IMM[v], V_MASK[v], 16, V_DLY[v], 1'b0);

    // R9: empty mask completes at once with zeros
    run_op(32'h0000_5000, 4'h3, 16'h0000, 16, 0, 1'b0);
    // R7: fault in the middle of a full mask, then on the first active lane
    run_op(32'h0000_6000, 4'h1, 16'hFFFF, 16, 0, 1'b0);
    run_op(32'h0000_7000, 4'h2, 16'hFFFF, 5, 0, 1'b0);
    run_op(32'h0000_8000, 4'h9, 16'h0F00, 8, 1, 1'b0);
    // R10: start held high with junk operands while busy
    run_op(32'h0000_9000, 4'h4, 16'h1234, 16, 1, 1'b1);
    // R9 again after a non-zero result: register must clear
    run_op(32'h0000_A000, 4'h0, 16'h0000, 16, 0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule